// File: doc/BRIEF.md
# Destination Byte FIFO Output Controller

This block is the output stage of a data-processing coprocessor. The processing unit hands it one byte at a time. The block stores the bytes in a byte-wide FIFO and offers them to an external DMA engine as 8-, 16- or 32-bit words. The DMA engine sees a request line and answers with an acknowledge. The block raises the request once the FIFO holds more than a programmable number of bytes. When the processing unit marks the last byte of a command, the block drains whatever is left, ignoring that threshold.

Each command loads a destination byte counter. The command can also ask for up to three filler bytes in front of the data, so that the first real byte lands on a chosen lane. The counter either stops output at zero and records an overrun, or it wraps, depending on a per-command flag.

The final word of a command may be partly filled. In that case the block marks it with a no-align flag and puts a count of its valid bytes into the top unused byte lane. An acknowledge while the FIFO is empty is recorded as a sticky data error.

Top module: `dest_fifo_out`

## Requirements
- R1: Outside a drain, the request rises when the FIFO count is greater than `cfg_thresh`. Once risen, it stays armed until the FIFO empties, so it is also raised at or below the threshold whenever a full word is present.
- R2: Outside a drain, the request is raised only if the FIFO holds at least one full word. A word is W bytes: W = 1, 2 or 4 for `cfg_width` codes 0, 1 and 2.
- R3: After the byte flagged `pu_last` has been taken, the request is raised whenever the FIFO is not empty, whatever the threshold.
- R4: Each transfer carries FIFO bytes in arrival order, with the oldest byte in bits 7:0 and the next in the next lane up. Lanes at or above the port width are driven zero.
- R5: On a final transfer, lanes after the valid bytes carry filler, which is zero in this implementation. After that transfer the FIFO is empty, so the next command's first byte starts in lane 0.
- R6: `dma_tc` is high while `dma_ack` is high on the final transfer of a command. `dma_noalign` is high on that transfer when its valid byte count is below W. In that case bits [8W-7:8W-8] carry the count minus one: 00 for one byte, 01 for two, 10 for three.
- R7: A command with `cmd_align` = N (0 to 3) puts N zero bytes into the FIFO ahead of the first processing-unit byte. Each of these bytes decrements the destination counter.
- R8: `dest_count` is loaded from `cmd_count` and decremented by one for every byte that enters the block.
- R9: With `cmd_ign_count` clear, a byte that arrives while `dest_count` is zero is consumed but not stored. `dest_count` holds at zero and `dest_overrun` is set; it stays set until the next command is loaded.
- R10: With `cmd_ign_count` set, a byte that arrives at count zero is stored and `dest_count` wraps to all ones.
- R11: `dma_ack` while the FIFO is empty sets `data_err`. The flag stays set until the next command is loaded, and that load clears it.
- R12: A command is accepted only while `idle` is high; `cmd_start` at any other time has no effect. `pu_ready` is low while filler bytes are being inserted, during a drain, when the FIFO is full, and when no command is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_width | input | 2 | Port width code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| cfg_thresh | input | $clog2(DEPTH)+1 | Request threshold, in bytes |
| cmd_start | input | 1 | Load a new command |
| cmd_align | input | 2 | Number of leading filler bytes |
| cmd_count | input | CNTW | Initial destination byte count |
| cmd_ign_count | input | 1 | Wrap at zero instead of stopping |
| idle | output | 1 | No command active and no drain in progress |
| pu_valid | input | 1 | Processing-unit byte valid |
| pu_byte | input | 8 | Processing-unit byte |
| pu_last | input | 1 | This byte is the last of the command |
| pu_ready | output | 1 | Block takes the byte this cycle |
| dma_req | output | 1 | Transfer request |
| dma_ack | input | 1 | Transfer acknowledge |
| dma_data | output | 32 | Output word |
| dma_tc | output | 1 | Final transfer of the command |
| dma_noalign | output | 1 | Final transfer is partly filled |
| dest_count | output | CNTW | Destination counter |
| dest_overrun | output | 1 | A byte was dropped at count zero |
| data_err | output | 1 | Acknowledge seen while the FIFO was empty |

## Verification
The two functions that can fall in the same cycle are a byte entering from the processing unit and a multi-byte word leaving on an acknowledge. The FIFO pointers and count then move in both directions at once. The bench provokes this by feeding bytes back to back while the acknowledge is given every cycle or every other cycle, with the FIFO held near full and near empty. The scoreboard judges it by comparing every acknowledged word, lane by lane, with the bytes queued in order. It also checks the terminal-count, no-align and valid-count fields against the number of bytes still expected.

// File: rtl/dfo_pkg.sv
package dfo_pkg;

    // Control state of the output controller.
    typedef struct packed {
        logic       cmd;    // command active, bytes may arrive
        logic       flush;  // last byte taken, draining
        logic [1:0] pad;    // filler bytes still to insert
        logic       hyst;   // request armed since threshold crossing
        logic       derr;   // sticky empty-read error
    } ctl_s;

    // Bytes per transfer for a width code.
    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dfo_byte_fifo.sv
module dfo_byte_fifo #(
    parameter int DEPTH = 16  // power of two, at least 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [7:0]                 push_byte,
    input  logic [2:0]                 pop_n,
    output logic [$clog2(DEPTH):0]     count,
    output logic [31:0]                peek
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fst_s;

    fst_s       st_q, st_d;
    logic [7:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = st_q.wr + AW'(1);
        st_d.rd  = st_q.rd + AW'(pop_n);
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wr] <= push_byte;
    end

    for (genvar i = 0; i < 4; i++) begin : g_peek
        assign peek[8*i +: 8] = mem[st_q.rd + AW'(i)];
    end

    assign count = st_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt < CW'(DEPTH)));  // R12
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(pop_n) <= st_q.cnt));  // R11

endmodule

// File: rtl/dfo_dest_counter.sv
module dfo_dest_counter #(
    parameter int CNTW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CNTW-1:0] load_val,
    input  logic            load_ign,
    input  logic            step,
    output logic [CNTW-1:0] count,
    output logic            accept,
    output logic            overrun
);
    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic            ign;
        logic            ovr;
    } cst_s;

    cst_s st_q, st_d;
    logic at_zero;

    always_comb begin
        at_zero = (st_q.cnt == '0);
        accept  = st_q.ign || !at_zero;
        st_d    = st_q;
        if (load) begin
            st_d.cnt = load_val;
            st_d.ign = load_ign;
            st_d.ovr = 1'b0;
        end else if (step) begin
            if (!at_zero)        st_d.cnt = st_q.cnt - CNTW'(1);
            else if (st_q.ign)   st_d.cnt = '1;
            else                 st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign overrun = st_q.ovr;

    AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && count != '0) |=> (count == $past(count) - CNTW'(1)));  // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !st_q.ign && count == '0) |=> (count == '0 && overrun));  // R9
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && st_q.ign && count == '0) |=> (&count));  // R10

endmodule

// File: rtl/dfo_word_pack.sv
module dfo_word_pack #(
    parameter int CW = 5
) (
    input  logic [1:0]    width_code,
    input  logic [CW-1:0] fifo_cnt,
    input  logic [31:0]   peek,
    input  logic          flush,
    output logic [31:0]   data,
    output logic [2:0]    nbytes,
    output logic          full_word,
    output logic          last_xfer,
    output logic          noalign
);
    import dfo_pkg::*;

    logic [2:0] wb;

    always_comb begin
        wb        = width_bytes(width_code);
        full_word = (fifo_cnt >= CW'(wb));
        last_xfer = flush && (fifo_cnt != '0) && (fifo_cnt <= CW'(wb));
        nbytes    = last_xfer ? fifo_cnt[2:0] : wb;
        noalign   = last_xfer && (nbytes != wb);
        data      = '0;
        for (int i = 0; i < 4; i++) begin
            if (3'(i) < nbytes) data[8*i +: 8] = peek[8*i +: 8];
        end
        if (noalign) begin
            if (wb == 3'd2) data[9:8]   = 2'(nbytes - 3'd1);
            else            data[25:24] = 2'(nbytes - 3'd1);
        end
    end

endmodule

// File: rtl/dest_fifo_out.sv
module dest_fifo_out #(
    parameter int DEPTH = 16,
    parameter int CNTW  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 cfg_width,
    input  logic [$clog2(DEPTH):0]     cfg_thresh,
    input  logic                       cmd_start,
    input  logic [1:0]                 cmd_align,
    input  logic [CNTW-1:0]            cmd_count,
    input  logic                       cmd_ign_count,
    output logic                       idle,
    input  logic                       pu_valid,
    input  logic [7:0]                 pu_byte,
    input  logic                       pu_last,
    output logic                       pu_ready,
    output logic                       dma_req,
    input  logic                       dma_ack,
    output logic [31:0]                dma_data,
    output logic                       dma_tc,
    output logic                       dma_noalign,
    output logic [CNTW-1:0]            dest_count,
    output logic                       dest_overrun,
    output logic                       data_err
);
    import dfo_pkg::*;

    localparam int CW = $clog2(DEPTH) + 1;

    ctl_s          ctl_q, ctl_d;
    logic [CW-1:0] fifo_cnt;
    logic [31:0]   peek;
    logic [2:0]    nbytes, pop_n;
    logic          full_word, last_xfer, noalign;
    logic          ctr_accept, load, room, pad_ins, take, step, push, above, pop;
    logic [7:0]    push_byte;

    dfo_byte_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_byte(push_byte),
        .pop_n(pop_n), .count(fifo_cnt), .peek(peek)
    );

    dfo_dest_counter #(.CNTW(CNTW)) i_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(cmd_count),
        .load_ign(cmd_ign_count), .step(step), .count(dest_count),
        .accept(ctr_accept), .overrun(dest_overrun)
    );

    dfo_word_pack #(.CW(CW)) i_pack (
        .width_code(cfg_width), .fifo_cnt(fifo_cnt), .peek(peek),
        .flush(ctl_q.flush), .data(dma_data), .nbytes(nbytes),
        .full_word(full_word), .last_xfer(last_xfer), .noalign(noalign)
    );

    always_comb begin
        idle      = !(ctl_q.cmd || ctl_q.flush);
        load      = cmd_start && idle;
        room      = (fifo_cnt < CW'(DEPTH));
        pad_ins   = ctl_q.cmd && (ctl_q.pad != 2'd0) && room;
        pu_ready  = ctl_q.cmd && (ctl_q.pad == 2'd0) && room;
        take      = pu_valid && pu_ready;
        step      = pad_ins || take;
        push      = pad_ins || (take && ctr_accept);
        push_byte = pad_ins ? 8'h00 : pu_byte;
        above     = (fifo_cnt > cfg_thresh);
        dma_req   = (fifo_cnt != '0) &&
                    (ctl_q.flush || ((ctl_q.hyst || above) && full_word));
        pop       = dma_ack && dma_req;
        pop_n     = pop ? nbytes : 3'd0;
        dma_tc      = pop && last_xfer;
        dma_noalign = noalign;
        data_err    = ctl_q.derr;

        ctl_d = ctl_q;
        if (load) begin
            ctl_d.cmd  = 1'b1;
            ctl_d.pad  = cmd_align;
            ctl_d.derr = 1'b0;
        end
        if (pad_ins) ctl_d.pad = ctl_q.pad - 2'd1;
        if (take && pu_last) begin
            ctl_d.cmd   = 1'b0;
            ctl_d.flush = 1'b1;
        end
        if (ctl_q.flush && (fifo_cnt == '0 || (pop && last_xfer))) ctl_d.flush = 1'b0;
        if (fifo_cnt == '0) ctl_d.hyst = 1'b0;
        else if (above)     ctl_d.hyst = 1'b1;
        if (dma_ack && fifo_cnt == '0) ctl_d.derr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> dma_req);  // R1
    AST_TC_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tc |=> (fifo_cnt == '0 && !dma_req));  // R5
    AST_DERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (data_err && !cmd_start) |=> data_err);  // R11

endmodule

// File: tb/test_dest_fifo_out.sv
module test_dest_fifo_out;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_width = 2'd2;
    logic [CW-1:0] cfg_thresh = '0;
    logic          cmd_start = 1'b0;
    logic [1:0]    cmd_align = '0;
    logic [31:0]   cmd_count = '0;
    logic          cmd_ign_count = 1'b0;
    logic          idle, pu_ready, dma_req, dma_tc, dma_noalign, dest_overrun, data_err;
    logic          pu_valid = 1'b0, pu_last = 1'b0, dma_ack = 1'b0;
    logic [7:0]    pu_byte = '0;
    logic [31:0]   dma_data, dest_count;

    int n_chk = 0, n_fail = 0;
    logic [7:0] q[$];
    logic [31:0] mcnt;
    bit mign, movr, last_in, mon_en, ack_mode, tog;
    logic [7:0] seed = 8'h10;

    always #2 clk = ~clk;

    dest_fifo_out #(.DEPTH(DEPTH), .CNTW(32)) i_dest_fifo_out (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_thresh(cfg_thresh),
        .cmd_start(cmd_start), .cmd_align(cmd_align), .cmd_count(cmd_count),
        .cmd_ign_count(cmd_ign_count), .idle(idle), .pu_valid(pu_valid),
        .pu_byte(pu_byte), .pu_last(pu_last), .pu_ready(pu_ready),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_data(dma_data),
        .dma_tc(dma_tc), .dma_noalign(dma_noalign), .dest_count(dest_count),
        .dest_overrun(dest_overrun), .data_err(data_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int wbf(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // model of one byte entering the block
    task automatic model_step(input logic [7:0] b);
        if (mcnt != 0) begin mcnt--; q.push_back(b); end
        else if (mign) begin mcnt = '1; q.push_back(b); end
        else movr = 1'b1;
    endtask

    task automatic push_b(input logic [7:0] b, input bit last);
        @(negedge clk);
        pu_valid = 1'b1; pu_byte = b; pu_last = last;
        while (!pu_ready) @(negedge clk);
        @(posedge clk); #1;
        pu_valid = 1'b0; pu_last = 1'b0;
        model_step(b);
        if (last) last_in = 1'b1;
    endtask

    task automatic load_cmd(input logic [1:0] w, input logic [CW-1:0] th, input logic [1:0] al,
                            input logic [31:0] cnt, input bit ign);
        @(negedge clk);
        while (!idle) @(negedge clk);
        cfg_width = w; cfg_thresh = th;
        cmd_start = 1'b1; cmd_align = al; cmd_count = cnt; cmd_ign_count = ign;
        @(posedge clk); #1;
        cmd_start = 1'b0;
        mcnt = cnt; mign = ign; movr = 1'b0; last_in = 1'b0;
        for (int i = 0; i < int'(al); i++) model_step(8'h00);
    endtask

    task automatic man_ack(input logic [31:0] exp_data, input bit exp_tc, input bit exp_na, input string tag);
        @(negedge clk);
        dma_ack = 1'b1; #1;
        chk(dma_data == exp_data, {tag, " data"}, dma_data, exp_data);
        chk(dma_tc == exp_tc, "R6 tc", 32'(dma_tc), 32'(exp_tc));
        chk(dma_noalign == exp_na, "R6 noalign", 32'(dma_noalign), 32'(exp_na));
        @(negedge clk);
        dma_ack = 1'b0;
    endtask

    task automatic run_cmd(input logic [1:0] w, input logic [CW-1:0] th, input logic [1:0] al,
                           input logic [31:0] cnt, input bit ign, input int nb, input bit am,
                           input string tag);
        ack_mode = am;
        load_cmd(w, th, al, cnt, ign);
        for (int i = 0; i < nb; i++) begin
            push_b(seed, i == nb - 1);
            seed = seed + 8'd7;
        end
        @(negedge clk);
        while (!(idle && q.size() == 0)) @(negedge clk);
        chk(dest_count == mcnt, {tag, " count"}, dest_count, mcnt);
        chk(dest_overrun == movr, "R9 overrun flag", 32'(dest_overrun), 32'(movr));
    endtask

    // scoreboard monitor: acknowledges and compares transfers
    initial begin
        forever begin
            @(negedge clk);
            tog = !tog;
            if (mon_en) begin
                dma_ack = 1'b0;
                if (dma_req && (!ack_mode || tog)) begin
                    int w, n;
                    bit el;
                    logic [31:0] ew;
                    w  = wbf(cfg_width);
                    n  = (q.size() < w) ? q.size() : w;
                    el = last_in && (q.size() <= w);
                    if (!last_in) chk(q.size() >= w, "R2 full word", 32'(q.size()), 32'(w));
                    chk(n > 0, "R4 queue empty", 32'(q.size()), 32'd1);
                    dma_ack = 1'b1; #1;
                    ew = '0;
                    for (int i = 0; i < 4; i++) if (i < n) ew[8*i +: 8] = q[i];
                    if (el && n < w) ew[8*(w-1) +: 2] = 2'(n - 1);
                    chk(dma_data == ew, el ? "R5 final word" : "R4 word", dma_data, ew);
                    chk(dma_tc == el, "R6 tc", 32'(dma_tc), 32'(el));
                    chk(dma_noalign == (el && n < w), "R6 noalign", 32'(dma_noalign), 32'(el && n < w));
                    for (int i = 0; i < n; i++) void'(q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        mon_en = 1'b0; ack_mode = 1'b0; tog = 1'b0; last_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dma_req, "R1 reset req", 32'(dma_req), 0);
        chk(idle, "R12 reset idle", 32'(idle), 1);
        chk(!pu_ready, "R12 reset ready", 32'(pu_ready), 0);
        chk(!data_err, "R11 reset err", 32'(data_err), 0);

        // R11: acknowledge on empty FIFO
        dma_ack = 1'b1;
        @(negedge clk); dma_ack = 1'b0;
        @(negedge clk);
        chk(data_err, "R11 empty read", 32'(data_err), 1);

        load_cmd(2'd2, CW'(5), 2'd0, 32'd100, 1'b0);
        @(negedge clk);
        chk(!data_err, "R11 cleared by load", 32'(data_err), 0);
        chk(pu_ready && !idle, "R12 ready after load", 32'(pu_ready), 1);
        // R12: start while busy is ignored
        cmd_start = 1'b1; cmd_count = 32'd7;
        @(negedge clk); cmd_start = 1'b0;
        @(negedge clk);
        chk(dest_count == 32'd100, "R12 busy start ignored", dest_count, 100);

        for (int i = 1; i <= 5; i++) push_b(8'(i), 1'b0);
        @(negedge clk);
        chk(!dma_req, "R1 at threshold", 32'(dma_req), 0);
        chk(dest_count == 32'd95, "R8 count", dest_count, 95);
        push_b(8'd6, 1'b0);
        @(negedge clk);
        chk(dma_req, "R1 above threshold", 32'(dma_req), 1);
        man_ack(32'h04030201, 1'b0, 1'b0, "R4");
        chk(!dma_req, "R2 partial word", 32'(dma_req), 0);
        push_b(8'd7, 1'b0);
        push_b(8'd8, 1'b0);
        @(negedge clk);
        chk(dma_req, "R1 armed below threshold", 32'(dma_req), 1);
        man_ack(32'h08070605, 1'b0, 1'b0, "R4");
        push_b(8'd9, 1'b1);
        @(negedge clk);
        chk(dma_req, "R3 drain below threshold", 32'(dma_req), 1);
        man_ack(32'h00000009, 1'b1, 1'b1, "R6");
        chk(!dma_req && idle, "R5 drained", 32'(dma_req), 0);
        q.delete();

        mon_en = 1'b1;
        run_cmd(2'd2, CW'(3), 2'd0, 32'd50, 1'b0, 10, 1'b0, "R8 two-byte tail");
        run_cmd(2'd2, CW'(8), 2'd1, 32'd40, 1'b0, 10, 1'b1, "R7 three-byte tail");
        run_cmd(2'd1, CW'(2), 2'd1, 32'd30, 1'b0, 6, 1'b0, "R7 half width");
        run_cmd(2'd0, CW'(0), 2'd0, 32'd30, 1'b0, 5, 1'b1, "R8 byte width");
        run_cmd(2'd2, CW'(4), 2'd3, 32'd20, 1'b0, 5, 1'b0, "R7 align three");
        run_cmd(2'd2, CW'(4), 2'd2, 32'd5, 1'b0, 9, 1'b0, "R9 overrun hold");
        run_cmd(2'd2, CW'(2), 2'd0, 32'd1, 1'b1, 3, 1'b0, "R10 wrap");
        run_cmd(2'd2, CW'(12), 2'd0, 32'd100, 1'b0, 40, 1'b1, "R8 long");
        chk(!data_err, "R11 no error in normal run", 32'(data_err), 0);
        summary();
    end
endmodule